// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

The block takes fixed-size interrupt vectors, eight 32-bit words each, from a source stream. It stores them one after another in a circular buffer held in local memory. A write pointer tracks where the next vector goes. A consumer reports how far it has read by writing a read pointer. Both pointers count bytes, so each stored vector moves the write pointer by 32.

While the consumer lags behind, the block holds an interrupt line high. When the ring fills, the configured policy decides what happens:
- **Flag mode:** the block overwrites the oldest entry and records the event in a sticky flag.
- **Overwrite mode:** the block overwrites the oldest entry and records nothing.
- **Stall mode:** the block stops accepting vectors until there is room.

Each change of the write-pointer word can also be posted on a writeback output, so the consumer can see the pointer without polling.

The source port is valid/ready. A vector is taken on a clock edge where `vec_valid` and `vec_ready` are both high, and the whole 256-bit vector moves in that single beat. `vec_ready` is low only in two cases: while the ring is disabled, and in stall mode while the ring is full. The source must hold `vec_data` stable while `vec_valid` is high and `vec_ready` is low. Configuration inputs are plain levels. The ring size may be changed only while the ring is disabled.

Top module: `ivr_ring_writer`

## Requirements
- R1: After reset the write-pointer word is 0, `irq_level`, `irq_rearm` and `wb_valid` are low, and `vec_ready` is low while `cfg_ring_en` is low.
- R2: The ring holds 4·2^L bytes, where L is `cfg_ring_size` clamped to the range 3 to MEM_LOG2_WORDS. An accepted vector is stored at entry wptr/32, with word k of the vector (bits 32k+31:32k) at word address wptr/4+k. The write pointer then becomes (wptr+32) modulo the ring size. The write-pointer word is presented on `wptr_word` as the byte pointer, with bit 0 used as the overflow flag.
- R3: The ring is full when (wptr+32) modulo the ring size equals the read pointer. In flag mode (`cfg_ovf_detect`=1), a vector accepted while the ring is full is still stored, the write pointer still advances, the read pointer is not moved, and bit 0 of `wptr_word` becomes 1 and stays 1.
- R4: In stall mode (`cfg_ovf_detect`=0, `cfg_full_drain`=1), `vec_ready` is low while the ring is full, and no vector is stored.
- R5: A cycle with `ovf_clear` high clears the overflow flag. If a new overflow occurs in the same cycle, the flag is set instead.
- R6: While `cfg_ring_en` is low, both pointers and the overflow flag are held at 0, `vec_ready` is low, and read-pointer writes are ignored.
- R7: A read-pointer write stores `rptr_wr_val` masked to the ring size and rounded down to a multiple of 32.
- R8: When `cfg_wb_en` is high, `wb_valid` pulses for one cycle in the cycle after any change of the write-pointer word. In that cycle `wb_word` carries the new value.
- R9: `irq_level` is high exactly when the ring is enabled, `cfg_intr_en` is high, and the read and write pointers differ.
- R10: When `cfg_rearm_en` and `cfg_intr_en` are high on an enabled ring, a read-pointer write that leaves the pointers unequal produces a one-cycle `irq_rearm` pulse in the next cycle.
- R11: `rd_data` returns, one cycle after `rd_word_addr` is presented, the memory word at that address. A write at the same edge is not yet visible.
- R12: With both `cfg_ovf_detect` and `cfg_full_drain` low, a vector accepted while the ring is full overwrites the oldest entry and leaves the overflow flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ring_en | input | 1 | Ring enable; low holds the pointers at zero |
| cfg_intr_en | input | 1 | Interrupt enable |
| cfg_ring_size | input | SIZE_W | log2 of the ring size in 32-bit words |
| cfg_ovf_detect | input | 1 | Flag mode: overwrite when full and set the sticky flag |
| cfg_full_drain | input | 1 | Stall mode: refuse vectors while full (only when `cfg_ovf_detect` is 0) |
| cfg_wb_en | input | 1 | Enables write-pointer writeback |
| cfg_rearm_en | input | 1 | Enables the re-arm pulse on read-pointer writes |
| ovf_clear | input | 1 | Clears the overflow flag |
| vec_valid | input | 1 | Source vector valid |
| vec_ready | output | 1 | Block accepts a vector |
| vec_data | input | 256 | Vector, word k in bits 32k+31:32k |
| rptr_wr_en | input | 1 | Read-pointer write strobe |
| rptr_wr_val | input | MEM_LOG2_WORDS+2 | Read pointer in bytes |
| wptr_word | output | 32 | Write pointer in bytes, with the overflow flag in bit 0 |
| wb_valid | output | 1 | Writeback strobe |
| wb_word | output | 32 | Posted write-pointer word |
| irq_level | output | 1 | Level interrupt: unread entries exist |
| irq_rearm | output | 1 | One-cycle re-arm pulse |
| rd_word_addr | input | MEM_LOG2_WORDS | Consumer read word address |
| rd_data | output | 32 | Read data, one cycle later |

## Verification
The bench drives the ring to exactly full and checks the following failure modes:
- A design that compares against the wrong slot would stall one entry early, or overwrite without raising the flag.
- A design that loses the flag would clear bit 0 on the next store instead of keeping it until `ovf_clear`.
- A read-pointer value that masks down to the current write pointer must drop `irq_level`; a design missing the alignment would keep interrupting.
- An out-of-range `cfg_ring_size` must clamp; a design that does not clamp would wrap at the wrong boundary.
- Writes made while the ring is disabled must leave no trace once it is re-enabled.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int WORD_W      = 32;
  localparam int ENTRY_WORDS = 8;
  localparam int ENTRY_BYTES = ENTRY_WORDS * WORD_W / 8;
  localparam int VEC_W       = ENTRY_WORDS * WORD_W;
  localparam int MIN_LOG2    = 3;

  typedef enum logic [1:0] {
    POL_OVERWRITE = 2'd0,
    POL_FLAG      = 2'd1,
    POL_STALL     = 2'd2
  } full_policy_e;
endpackage

// File: rtl/ivr_ptr_ctrl.sv
module ivr_ptr_ctrl
  import ivr_pkg::*;
#(
  parameter int PTR_W    = 9,
  parameter int SIZE_W   = 5,
  parameter int MAX_LOG2 = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ovf_detect,
  input  logic              full_drain,
  input  logic [SIZE_W-1:0] ring_size,
  input  logic              vec_valid,
  output logic              vec_ready,
  output logic              fire,
  input  logic              rptr_wr_en,
  input  logic [PTR_W-1:0]  rptr_wr_val,
  input  logic              ovf_clear,
  output logic [PTR_W-1:0]  wptr_q,
  output logic [PTR_W-1:0]  rptr_q,
  output logic              ovf_q,
  output logic [PTR_W-1:0]  wptr_d,
  output logic [PTR_W-1:0]  rptr_d,
  output logic              ovf_d
);
  localparam logic [PTR_W-1:0] STEP  = PTR_W'(ENTRY_BYTES);
  localparam logic [PTR_W-1:0] ALIGN = ~PTR_W'(ENTRY_BYTES - 1);

  logic [PTR_W-1:0] mask;
  logic [PTR_W-1:0] wptr_step;
  logic             full;
  full_policy_e     policy;
  int               eff_log2;

  always_comb begin
    eff_log2 = int'(ring_size);
    if (eff_log2 < MIN_LOG2) eff_log2 = MIN_LOG2;
    if (eff_log2 > MAX_LOG2) eff_log2 = MAX_LOG2;
    for (int i = 0; i < PTR_W; i++) mask[i] = (i < eff_log2 + 2);
  end

  always_comb begin
    if (ovf_detect)      policy = POL_FLAG;
    else if (full_drain) policy = POL_STALL;
    else                 policy = POL_OVERWRITE;
  end

  assign wptr_step = (wptr_q + STEP) & mask;
  assign full      = (wptr_step == rptr_q);
  assign vec_ready = en && !(full && policy == POL_STALL);
  assign fire      = vec_valid && vec_ready;

  always_comb begin
    if (!en) begin
      wptr_d = '0;
      rptr_d = '0;
      ovf_d  = 1'b0;
    end else begin
      rptr_d = rptr_wr_en ? (rptr_wr_val & mask & ALIGN) : rptr_q;
      wptr_d = fire ? wptr_step : wptr_q;
      if (fire && full && policy == POL_FLAG) ovf_d = 1'b1;
      else if (ovf_clear)                     ovf_d = 1'b0;
      else                                    ovf_d = ovf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      ovf_q  <= ovf_d;
    end
  end

  // R4: stall mode refuses vectors while full
  a_r4_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (en && full && !ovf_detect && full_drain) |-> !vec_ready);

  // R6: disabled ring returns to zero pointers
  a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (wptr_q == '0 && rptr_q == '0 && !ovf_q));

  // R3: overflow flag is sticky until cleared
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ovf_q && !ovf_clear) |=> ovf_q);

  // R2: write pointer moves only on an accepted vector
  a_r2_wptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !fire) |=> $stable(wptr_q));
endmodule

// File: rtl/ivr_store.sv
module ivr_store
  import ivr_pkg::*;
#(
  parameter int MEM_LOG2_WORDS = 7
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [MEM_LOG2_WORDS-4:0] w_entry,
  input  logic [VEC_W-1:0]          w_vec,
  input  logic [MEM_LOG2_WORDS-1:0] rd_word_addr,
  output logic [WORD_W-1:0]         rd_data
);
  localparam int ENTRIES = (2 ** MEM_LOG2_WORDS) / ENTRY_WORDS;

  logic [WORD_W-1:0] bank_q [ENTRY_WORDS];
  logic [2:0]        sel_q;

  for (genvar k = 0; k < ENTRY_WORDS; k++) begin : g_bank
    logic [WORD_W-1:0] mem [ENTRIES];
    always_ff @(posedge clk) begin
      if (we) mem[w_entry] <= w_vec[k*WORD_W +: WORD_W];
      bank_q[k] <= mem[rd_word_addr[MEM_LOG2_WORDS-1:3]];
    end
  end

  always_ff @(posedge clk) sel_q <= rd_word_addr[2:0];

  assign rd_data = bank_q[sel_q];

  // R2: a store never targets an unknown entry
  a_r2_known_entry: assert property (@(posedge clk) we |-> !$isunknown(w_entry));
endmodule

// File: rtl/ivr_notify.sv
module ivr_notify #(
  parameter int PTR_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             intr_en,
  input  logic             wb_en,
  input  logic             rearm_en,
  input  logic             rptr_wr_en,
  input  logic [PTR_W-1:0] wptr_q,
  input  logic [PTR_W-1:0] rptr_q,
  input  logic             ovf_q,
  input  logic [PTR_W-1:0] wptr_d,
  input  logic [PTR_W-1:0] rptr_d,
  input  logic             ovf_d,
  output logic [31:0]      wptr_word,
  output logic             wb_valid,
  output logic [31:0]      wb_word,
  output logic             irq_level,
  output logic             irq_rearm
);
  logic [31:0] word_d;

  assign wptr_word = {{(32-PTR_W){1'b0}}, wptr_q[PTR_W-1:1], wptr_q[0] | ovf_q};
  assign word_d    = {{(32-PTR_W){1'b0}}, wptr_d[PTR_W-1:1], wptr_d[0] | ovf_d};
  assign irq_level = en && intr_en && (rptr_q != wptr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid  <= 1'b0;
      wb_word   <= '0;
      irq_rearm <= 1'b0;
    end else begin
      wb_valid  <= wb_en && (word_d != wptr_word);
      wb_word   <= word_d;
      irq_rearm <= en && intr_en && rearm_en && rptr_wr_en && (rptr_d != wptr_d);
    end
  end

  // R8: posted word matches the live write-pointer word
  a_r8_wb_matches: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_word == wptr_word));

  // R10: a re-arm pulse only comes with pending entries
  a_r10_pulse_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rearm && en && intr_en) |-> irq_level);
endmodule

// File: rtl/ivr_ring_writer.sv
module ivr_ring_writer
  import ivr_pkg::*;
#(
  parameter int MEM_LOG2_WORDS = 7,
  parameter int SIZE_W         = 5,
  localparam int PTR_W         = MEM_LOG2_WORDS + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_ring_en,
  input  logic                      cfg_intr_en,
  input  logic [SIZE_W-1:0]         cfg_ring_size,
  input  logic                      cfg_ovf_detect,
  input  logic                      cfg_full_drain,
  input  logic                      cfg_wb_en,
  input  logic                      cfg_rearm_en,
  input  logic                      ovf_clear,
  input  logic                      vec_valid,
  output logic                      vec_ready,
  input  logic [255:0]              vec_data,
  input  logic                      rptr_wr_en,
  input  logic [PTR_W-1:0]          rptr_wr_val,
  output logic [31:0]               wptr_word,
  output logic                      wb_valid,
  output logic [31:0]               wb_word,
  output logic                      irq_level,
  output logic                      irq_rearm,
  input  logic [MEM_LOG2_WORDS-1:0] rd_word_addr,
  output logic [31:0]               rd_data
);
  logic             fire;
  logic [PTR_W-1:0] wptr_q, rptr_q, wptr_d, rptr_d;
  logic             ovf_q, ovf_d;

  ivr_ptr_ctrl #(.PTR_W(PTR_W), .SIZE_W(SIZE_W), .MAX_LOG2(MEM_LOG2_WORDS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .en(cfg_ring_en), .ovf_detect(cfg_ovf_detect),
    .full_drain(cfg_full_drain), .ring_size(cfg_ring_size),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .fire(fire),
    .rptr_wr_en(rptr_wr_en), .rptr_wr_val(rptr_wr_val), .ovf_clear(ovf_clear),
    .wptr_q(wptr_q), .rptr_q(rptr_q), .ovf_q(ovf_q),
    .wptr_d(wptr_d), .rptr_d(rptr_d), .ovf_d(ovf_d)
  );

  ivr_store #(.MEM_LOG2_WORDS(MEM_LOG2_WORDS)) u_store (
    .clk(clk), .we(fire), .w_entry(wptr_q[PTR_W-1:5]), .w_vec(vec_data),
    .rd_word_addr(rd_word_addr), .rd_data(rd_data)
  );

  ivr_notify #(.PTR_W(PTR_W)) u_notify (
    .clk(clk), .rst_n(rst_n), .en(cfg_ring_en), .intr_en(cfg_intr_en),
    .wb_en(cfg_wb_en), .rearm_en(cfg_rearm_en), .rptr_wr_en(rptr_wr_en),
    .wptr_q(wptr_q), .rptr_q(rptr_q), .ovf_q(ovf_q),
    .wptr_d(wptr_d), .rptr_d(rptr_d), .ovf_d(ovf_d),
    .wptr_word(wptr_word), .wb_valid(wb_valid), .wb_word(wb_word),
    .irq_level(irq_level), .irq_rearm(irq_rearm)
  );

  // R1: nothing is accepted while the ring is off
  a_r1_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ring_en |-> !vec_ready);
endmodule

// File: tb/ivr_ring_writer_tb.sv
module ivr_ring_writer_tb;
  localparam int MLW = 7;
  localparam int PW  = MLW + 2;
  localparam int ENT = (2 ** MLW) / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c_en = 0, c_ie = 0, c_ovf = 0, c_drain = 0, c_wb = 0, c_rearm = 0;
  logic [4:0] c_size = 5'd5;
  logic ovf_clear = 0, vec_valid = 0, rptr_wr_en = 0;
  logic [255:0] vec_data = '0;
  logic [PW-1:0] rptr_wr_val = '0;
  logic [MLW-1:0] rd_word_addr = '0;
  logic vec_ready, wb_valid, irq_level, irq_rearm;
  logic [31:0] wptr_word, wb_word, rd_data;

  int nchk = 0, nfail = 0;
  bit done = 0;

  int m_w = 0, m_r = 0;
  bit m_o = 0, m_wbv = 0, m_pls = 0, m_rdv = 0;
  logic [31:0] m_wbd = '0, m_rdd = '0;
  logic [31:0] m_mem [ENT][8];
  bit m_ok [ENT];

  always #2 clk = ~clk;

  ivr_ring_writer #(.MEM_LOG2_WORDS(MLW), .SIZE_W(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ring_en(c_en), .cfg_intr_en(c_ie),
    .cfg_ring_size(c_size), .cfg_ovf_detect(c_ovf), .cfg_full_drain(c_drain),
    .cfg_wb_en(c_wb), .cfg_rearm_en(c_rearm), .ovf_clear(ovf_clear),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data),
    .rptr_wr_en(rptr_wr_en), .rptr_wr_val(rptr_wr_val), .wptr_word(wptr_word),
    .wb_valid(wb_valid), .wb_word(wb_word), .irq_level(irq_level),
    .irq_rearm(irq_rearm), .rd_word_addr(rd_word_addr), .rd_data(rd_data)
  );

  function automatic int ring_mask(input int sz);
    int lw = sz;
    if (lw < 3) lw = 3;
    if (lw > MLW) lw = MLW;
    return (4 << lw) - 1;
  endfunction

  function automatic logic [255:0] rnd_vec();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input logic [255:0] d, input bit rw,
                      input int rv, input bit clr, input int ra);
    int mk, nw, nr, ent;
    bit full, rdy, fire, no;
    logic [31:0] wq, wd;
    vec_valid = v; vec_data = d; rptr_wr_en = rw; rptr_wr_val = PW'(rv);
    ovf_clear = clr; rd_word_addr = MLW'(ra);
    #1;
    mk   = ring_mask(int'(c_size));
    full = (((m_w + 32) & mk) == m_r);
    rdy  = c_en && !(full && !c_ovf && c_drain);
    chk("R4 vec_ready", 32'(vec_ready), 32'(rdy));
    fire  = v && rdy;
    m_rdv = m_ok[(ra >> 3) % ENT];
    m_rdd = m_mem[(ra >> 3) % ENT][ra & 7];
    if (fire) begin
      ent = m_w >> 5;
      for (int k = 0; k < 8; k++) m_mem[ent][k] = d[32*k +: 32];
      m_ok[ent] = 1;
    end
    if (!c_en) begin
      nw = 0; nr = 0; no = 0;
    end else begin
      nr = rw ? ((rv & ((1 << PW) - 1)) & mk & ~31) : m_r;
      nw = fire ? ((m_w + 32) & mk) : m_w;
      no = (fire && full && c_ovf) ? 1'b1 : (clr ? 1'b0 : m_o);
    end
    wq = 32'(m_w) | 32'(m_o);
    wd = 32'(nw) | 32'(no);
    m_wbv = c_wb && (wd != wq);
    m_wbd = wd;
    m_pls = c_en && c_ie && c_rearm && rw && (nr != nw);
    m_w = nw; m_r = nr; m_o = no;
    @(posedge clk);
    @(negedge clk);
    chk("R2 wptr_word", wptr_word, 32'(m_w) | 32'(m_o));
    chk("R9 irq_level", 32'(irq_level), 32'(c_en && c_ie && (m_r != m_w)));
    chk("R8 wb_valid", 32'(wb_valid), 32'(m_wbv));
    if (m_wbv) chk("R8 wb_word", wb_word, m_wbd);
    chk("R10 irq_rearm", 32'(irq_rearm), 32'(m_pls));
    if (m_rdv) chk("R11 rd_data", rd_data, m_rdd);
  endtask

  task automatic idle();
    step(0, '0, 0, 0, 0, 0);
  endtask

  task automatic push();
    step(1, rnd_vec(), 0, 0, 0, int'($urandom % 128));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d));
    for (int i = 0; i < ENT; i++) m_ok[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset wptr_word", wptr_word, 32'h0);
    chk("R1 reset irq_level", 32'(irq_level), 32'h0);
    chk("R1 reset wb_valid", 32'(wb_valid), 32'h0);
    chk("R1 reset irq_rearm", 32'(irq_rearm), 32'h0);
    chk("R1 reset vec_ready", 32'(vec_ready), 32'h0);
    rst_n = 1'b1;
    idle();

    // ring of 128 bytes (4 entries), stall mode
    c_size = 5'd5; c_en = 1; c_ie = 1; c_wb = 1; c_drain = 1; c_ovf = 0; c_rearm = 1;
    repeat (3) push();
    #1 chk("R4 full stall ready", 32'(vec_ready), 32'h0);
    push();
    chk("R4 stalled wptr", wptr_word, 32'd96);
    step(0, '0, 1, 64, 0, 0);
    chk("R10 rearm pulse", 32'(irq_rearm), 32'h1);

    // flag mode
    c_ovf = 1;
    repeat (3) push();
    chk("R3 overflow flag set", wptr_word, 32'd65);
    push();
    chk("R3 flag stays", wptr_word, 32'd97);
    step(0, '0, 0, 0, 1, 0);
    chk("R5 overflow cleared", wptr_word, 32'd96);

    // read-pointer masking
    step(0, '0, 1, 32'h1E7, 0, 0);
    chk("R7 masked rptr equals wptr", 32'(irq_level), 32'h0);
    step(0, '0, 1, 32'h1AB, 0, 0);
    chk("R7 masked rptr differs", 32'(irq_level), 32'h1);

    // disable
    c_en = 0;
    idle();
    chk("R6 disabled wptr", wptr_word, 32'h0);
    #1 chk("R6 disabled ready", 32'(vec_ready), 32'h0);
    step(0, '0, 1, 64, 0, 0);
    c_en = 1;
    #1 chk("R6 rptr write ignored", 32'(irq_level), 32'h0);

    // overwrite mode, 64-byte ring
    c_en = 0; idle();
    c_size = 5'd4; c_ovf = 0; c_drain = 0; c_en = 1;
    repeat (3) push();
    chk("R12 overwrite no flag", wptr_word, 32'd32);

    // size clamp
    c_en = 0; idle();
    c_size = 5'd31; c_en = 1;
    repeat (5) push();
    chk("R2 clamped size wptr", wptr_word, 32'd160);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 60 == 0) c_en = ~c_en;
      if (!c_en && ($urandom % 4 == 0)) c_size = 5'($urandom % 10);
      if ($urandom % 40 == 0) c_ovf = $urandom % 2;
      if ($urandom % 40 == 0) c_drain = $urandom % 2;
      if ($urandom % 50 == 0) c_ie = $urandom % 2;
      if ($urandom % 50 == 0) c_wb = $urandom % 2;
      if ($urandom % 50 == 0) c_rearm = $urandom % 2;
      step($urandom % 3 != 0, rnd_vec(), $urandom % 5 == 0, int'($urandom % 512),
           $urandom % 20 == 0, int'($urandom % 128));
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule